// File: doc/BRIEF.md
# Regulator Start-Up and Latch-Off Sequencer

This block orders the power-up of a multiphase buck regulator controller and owns its overcurrent shutdown. Once the supply is above its lockout level and the enable input is high, it walks through a start delay, a fixed phase-detection window, a soft-start interval and a power-good delay. Only after that does it raise power-good. All analog quantities reach it as digital flags: soft start close to its target, the blanking mask finished, current limit active and phase detection finished.

A single delay counter stands in for the external timing capacitor. The counter serves both start-up delays at a fast rate of four counts per clock. In normal operation it serves as the overcurrent latch-off timer at one count per clock, so the latch-off interval is four times longer. The latch-off timer is armed only after power-good has been raised. An overcurrent that goes away before the threshold clears the counter, and switching continues throughout. A bypass input keeps the counter just below its threshold, so the block never latches off while the bypass is high.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Whenever `supply_ok` or `enable_in` is low at a rising edge, after that edge `drv_enable`, `pwm_en`, `ss_en`, `pgood` and `fault_latched` are all 0 and the delay counter is cleared. When both inputs return high, the full sequence restarts from the start delay.
- R2: The first rising edge that sees both `supply_ok` and `enable_in` high sets `drv_enable` to 1. The start delay then adds STEP_FAST per clock from zero until the counter reaches DLY_THRESH.
- R3: The phase-detection window follows the start delay. It lasts PHASE_CYCLES clocks and is extended for as long as `phase_det_done` is low. `pwm_en` stays 0 throughout the window. With defaults-like settings where N = DLY_THRESH/STEP_FAST, and with `phase_det_done` high, `pwm_en` first reads 1 after the (N+6)th rising edge counted from the enabling edge.
- R4: Soft start lasts until `ss_near_target` and `blank_done` are both high at an edge. The power-good delay then runs at the fast rate, and `pgood` rises when it finishes. With both flags already high, `pgood` first reads 1 after edge 2N+8.
- R5: `ilim_active` has no effect until `pgood` is high. With current limit held from the start, `pgood` still rises after edge 2N+8, and the latch-off count starts only from that point.
- R6: With `pgood` high and `ilim_active` held high, the counter adds STEP_SLOW per clock. `fault_latched` rises on the (DLY_THRESH/STEP_SLOW + 1)th edge that sees `ilim_active` high.
- R7: If `ilim_active` drops before the latch edge, the counter returns to zero and no fault is recorded. `pwm_en` and `pgood` stay 1 during the count, and a later pulse starts counting from zero again.
- R8: Once latched, `drv_enable`, `pwm_en`, `ss_en` and `pgood` are 0 and `fault_latched` is 1. These values hold regardless of `ilim_active`. The latch clears only on an edge with `enable_in` or `supply_ok` low.
- R9: While `latch_bypass` is high, the latch-off count saturates one below DLY_THRESH and no fault is latched. If the bypass drops with current limit still present, the fault latches on the second following edge.
- R10: `ss_en` is 1 exactly in soft start, in the power-good delay and in normal operation, so it matches `pwm_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above undervoltage lockout |
| enable_in | input | 1 | Regulator enable |
| phase_det_done | input | 1 | Phase detection finished |
| ss_near_target | input | 1 | Soft-start level within margin of target |
| blank_done | input | 1 | Power-good blanking mask finished |
| ilim_active | input | 1 | Current limit comparator active |
| latch_bypass | input | 1 | Keep latch-off timer below threshold |
| drv_enable | output | 1 | Low forces external drivers off |
| pwm_en | output | 1 | PWM outputs allowed to switch |
| ss_en | output | 1 | Soft-start amplifier enabled |
| pgood | output | 1 | Power good |
| fault_latched | output | 1 | Overcurrent latch-off recorded |

## Verification
The bench builds the block with DLY_THRESH = 16, STEP_FAST = 4, STEP_SLOW = 1 and PHASE_CYCLES = 4. With these values the start and power-good delays take five clocks each, and latch-off takes seventeen. That makes it practical to compare every output on every clock of a start-up against arithmetic expectations. It also makes it practical to sweep every current-limit pulse length from one clock to the first length that latches. The small threshold keeps the bypass saturation point and the two-edge latch after bypass release within a few clocks of observation.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the start-up and latch-off sequencer.
// Assumes: consumers import the package; encodings are internal only.
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_OFF   = 3'd0,
        SEQ_TD1   = 3'd1,
        SEQ_PHASE = 3'd2,
        SEQ_SOFT  = 3'd3,
        SEQ_TD3   = 3'd4,
        SEQ_RUN   = 3'd5,
        SEQ_LATCH = 3'd6
    } seq_state_t;

    typedef enum logic [1:0] {
        TMR_CLEAR = 2'd0,
        TMR_FAST  = 2'd1,
        TMR_SLOW  = 2'd2
    } tmr_mode_t;

endpackage

// File: rtl/seq_delay_timer.sv
// Digital stand-in for the delay capacitor: a counter that is cleared,
// advanced by a fast step or advanced by a slow step, and flags expiry at
// THRESH. With the bypass variant built in, slow counting saturates one
// below THRESH while hold_below is high.
// Assumes: THRESH >= STEP_FAST >= 1 and STEP_SLOW >= 1.
module seq_delay_timer
    import pwr_seq_pkg::*;
#(
    parameter int THRESH    = 64,
    parameter int STEP_FAST = 4,
    parameter int STEP_SLOW = 1,
    parameter bit BYPASS_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tmr_mode_t mode,
    input  logic      hold_below,
    output logic      expired
);

    localparam int CW = $clog2(THRESH + STEP_FAST + 1) + 1;
    localparam logic [CW-1:0] LIM  = CW'(THRESH);
    localparam logic [CW-1:0] FSTP = CW'(STEP_FAST);
    localparam logic [CW-1:0] SSTP = CW'(STEP_SLOW);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_sum;
    logic          hold_eff;

    // Select whether the bypass input is wired in at all.
    generate
        if (BYPASS_EN) begin : g_bypass
            assign hold_eff = hold_below;
        end else begin : g_no_bypass
            assign hold_eff = 1'b0;
        end
    endgenerate

    // Candidate next count for the current rate.
    always_comb begin
        cnt_sum = cnt_q + ((mode == TMR_SLOW) ? SSTP : FSTP);
    end

    // Counter register: clear, hold at expiry, saturate under bypass, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (mode == TMR_CLEAR) begin
            cnt_q <= '0;
        end else if (cnt_q >= LIM) begin
            cnt_q <= cnt_q;
        end else if (mode == TMR_SLOW && hold_eff && cnt_sum >= LIM) begin
            cnt_q <= LIM - 1'b1;
        end else begin
            cnt_q <= cnt_sum;
        end
    end

    assign expired = (cnt_q >= LIM);

    // R6: an unbypassed slow tick below threshold adds exactly the slow step.
    assert_slow_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TMR_SLOW && !hold_eff && cnt_q < LIM)
        |=> (cnt_q == $past(cnt_q) + SSTP));

    // R9: a bypassed slow tick never lands on the threshold.
    assert_bypass_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TMR_SLOW && hold_eff && cnt_q < LIM) |=> !expired);

    // R1: a clear request empties the counter by the next edge.
    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TMR_CLEAR) |=> (cnt_q == '0));

endmodule

// File: rtl/seq_phase_window.sv
// Fixed-length window counter for phase detection. Counts clocks while
// in_window is high and reports done from the last window clock onward.
// Assumes: CYCLES >= 1; in_window drops when the window is left.
module seq_phase_window #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_window,
    output logic done
);

    localparam int WW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [WW-1:0] LAST = WW'(CYCLES - 1);

    logic [WW-1:0] cnt_q;

    // Window clock counter, saturating at the last window clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!in_window) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = in_window && (cnt_q == LAST);

    // R3: the window can only finish after it has been open for a clock,
    // unless it is a single-clock window.
    assert_window_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && CYCLES > 1) |-> $past(in_window));

endmodule

// File: rtl/seq_fsm.sv
// Sequencing state machine: off, start delay, phase window, soft start,
// power-good delay, run, latched. Also chooses the delay-timer rate.
// Assumes: power_ok is supply-above-lockout AND enable, already combined.
module seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       power_ok,
    input  logic       tmr_expired,
    input  logic       win_done,
    input  logic       phase_det_done,
    input  logic       ss_near_target,
    input  logic       blank_done,
    input  logic       ilim_active,
    output seq_state_t state,
    output tmr_mode_t  tmr_mode,
    output logic       win_active
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Next-state decision; losing power overrides every state.
    always_comb begin
        state_d = state_q;
        if (!power_ok) begin
            state_d = SEQ_OFF;
        end else begin
            unique case (state_q)
                SEQ_OFF:   state_d = SEQ_TD1;
                SEQ_TD1:   if (tmr_expired) state_d = SEQ_PHASE;
                SEQ_PHASE: if (win_done && phase_det_done) state_d = SEQ_SOFT;
                SEQ_SOFT:  if (ss_near_target && blank_done) state_d = SEQ_TD3;
                SEQ_TD3:   if (tmr_expired) state_d = SEQ_RUN;
                SEQ_RUN:   if (ilim_active && tmr_expired) state_d = SEQ_LATCH;
                SEQ_LATCH: state_d = SEQ_LATCH;
                default:   state_d = SEQ_OFF;
            endcase
        end
    end

    // Timer rate: fast for both start-up delays, slow under current limit.
    always_comb begin
        tmr_mode = TMR_CLEAR;
        if (power_ok) begin
            unique case (state_q)
                SEQ_TD1, SEQ_TD3: tmr_mode = tmr_expired ? TMR_CLEAR : TMR_FAST;
                SEQ_RUN:          tmr_mode = (ilim_active && !tmr_expired) ? TMR_SLOW : TMR_CLEAR;
                default:          tmr_mode = TMR_CLEAR;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign state      = state_q;
    assign win_active = (state_q == SEQ_PHASE);

    // R3: the phase window cannot be left while detection is unfinished.
    assert_phase_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PHASE && power_ok && !phase_det_done)
        |=> (state_q == SEQ_PHASE));

    // R4: soft start persists until both completion flags are seen.
    assert_soft_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SOFT && power_ok && !(ss_near_target && blank_done))
        |=> (state_q == SEQ_SOFT));

    // R5: latch-off is reachable only from normal operation.
    assert_latch_only_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_RUN && state_q != SEQ_LATCH) |=> (state_q != SEQ_LATCH));

    // R8: the latched state holds while power stays valid.
    assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LATCH && power_ok) |=> (state_q == SEQ_LATCH));

endmodule

// File: rtl/pwr_seq_ctrl.sv
// Top of the regulator start-up and overcurrent latch-off sequencer.
// Combines supply and enable, runs the state machine, the shared delay
// timer and the phase window, and decodes the five control outputs.
// Assumes: all inputs are synchronous to clk.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int DLY_THRESH   = 64,
    parameter int STEP_FAST    = 4,
    parameter int STEP_SLOW    = 1,
    parameter int PHASE_CYCLES = 4,
    parameter bit BYPASS_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic enable_in,
    input  logic phase_det_done,
    input  logic ss_near_target,
    input  logic blank_done,
    input  logic ilim_active,
    input  logic latch_bypass,
    output logic drv_enable,
    output logic pwm_en,
    output logic ss_en,
    output logic pgood,
    output logic fault_latched
);

    logic       power_ok;
    logic       tmr_expired;
    logic       win_done;
    logic       win_active;
    seq_state_t state;
    tmr_mode_t  tmr_mode;

    assign power_ok = supply_ok & enable_in;

    seq_fsm i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .power_ok       (power_ok),
        .tmr_expired    (tmr_expired),
        .win_done       (win_done),
        .phase_det_done (phase_det_done),
        .ss_near_target (ss_near_target),
        .blank_done     (blank_done),
        .ilim_active    (ilim_active),
        .state          (state),
        .tmr_mode       (tmr_mode),
        .win_active     (win_active)
    );

    seq_delay_timer #(
        .THRESH    (DLY_THRESH),
        .STEP_FAST (STEP_FAST),
        .STEP_SLOW (STEP_SLOW),
        .BYPASS_EN (BYPASS_EN)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (tmr_mode),
        .hold_below (latch_bypass),
        .expired    (tmr_expired)
    );

    seq_phase_window #(
        .CYCLES (PHASE_CYCLES)
    ) i_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (win_active),
        .done      (win_done)
    );

    // Output decode from the sequencing state.
    always_comb begin
        drv_enable    = (state != SEQ_OFF) && (state != SEQ_LATCH);
        pwm_en        = (state == SEQ_SOFT) || (state == SEQ_TD3) || (state == SEQ_RUN);
        ss_en         = pwm_en;
        pgood         = (state == SEQ_RUN);
        fault_latched = (state == SEQ_LATCH);
    end

    // R1: an edge without supply or enable leaves every output low.
    assert_off_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_ok && enable_in)
        |=> (!drv_enable && !pwm_en && !ss_en && !pgood && !fault_latched));

    // R4: power-good only rises out of an active switching phase.
    assert_pgood_after_switching_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(pwm_en));

    // R6: a new fault needs current limit seen at the deciding edge.
    assert_fault_needs_ilim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_latched) |-> ($past(ilim_active) && $past(pgood)));

    // R8: a latched fault keeps drivers released-off.
    assert_fault_drivers_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> (!drv_enable && !pwm_en && !pgood));

endmodule

// File: tb/test_pwr_seq_ctrl.sv
// Self-checking bench: per-clock sweeps of start-up and of current-limit
// pulse lengths on a small configuration, expectations computed here.
module test_pwr_seq_ctrl;

    localparam int TH = 16;
    localparam int FS = 4;
    localparam int SS = 1;
    localparam int NN = TH / FS;
    localparam int TS = TH / SS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic enable_in = 1'b0;
    logic phase_det_done = 1'b1;
    logic ss_near_target = 1'b1;
    logic blank_done = 1'b1;
    logic ilim_active = 1'b0;
    logic latch_bypass = 1'b0;
    logic drv_enable, pwm_en, ss_en, pgood, fault_latched;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pwr_seq_ctrl #(
        .DLY_THRESH   (TH),
        .STEP_FAST    (FS),
        .STEP_SLOW    (SS),
        .PHASE_CYCLES (4),
        .BYPASS_EN    (1'b1)
    ) i_pwr_seq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .enable_in      (enable_in),
        .phase_det_done (phase_det_done),
        .ss_near_target (ss_near_target),
        .blank_done     (blank_done),
        .ilim_active    (ilim_active),
        .latch_bypass   (latch_bypass),
        .drv_enable     (drv_enable),
        .pwm_en         (pwm_en),
        .ss_en          (ss_en),
        .pgood          (pgood),
        .fault_latched  (fault_latched)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic all_low(input string tag);
        chk({tag, " drv_enable"}, drv_enable, 1'b0);
        chk({tag, " pwm_en"}, pwm_en, 1'b0);
        chk({tag, " pgood"}, pgood, 1'b0);
        chk({tag, " fault_latched"}, fault_latched, 1'b0);
    endtask

    task automatic bring_up();
        enable_in = 1'b0;
        tick();
        enable_in = 1'b1;
        repeat (2 * NN + 8) tick();
        chk("R4 bring-up pgood", pgood, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        all_low("R1 reset");
        rst_n = 1'b1;
        repeat (3) tick();
        all_low("R1 enable low");

        // R2 R3 R4 R10: per-clock start-up sweep
        enable_in = 1'b1;
        for (int k = 1; k <= 2 * NN + 10; k++) begin
            tick();
            chk("R2 drv_enable", drv_enable, 1'b1);
            chk("R3 pwm_en", pwm_en, k >= NN + 6);
            chk("R10 ss_en", ss_en, k >= NN + 6);
            chk("R4 pgood", pgood, k >= 2 * NN + 8);
        end

        // R6 R7: continuous current limit latches after TS+1 edges
        ilim_active = 1'b1;
        for (int k = 1; k <= TS + 1; k++) begin
            tick();
            chk("R6 fault timing", fault_latched, k >= TS + 1);
            chk("R7 switching during count", pwm_en, k < TS + 1);
        end

        // R8: sticky latch, cleared only by enable low
        ilim_active = 1'b0;
        repeat (4) tick();
        chk("R8 fault held", fault_latched, 1'b1);
        chk("R8 drivers off", drv_enable, 1'b0);
        chk("R8 pwm off", pwm_en, 1'b0);
        chk("R8 pgood off", pgood, 1'b0);
        enable_in = 1'b0;
        tick();
        chk("R8 enable clears", fault_latched, 1'b0);

        // R6 R7: sweep of pulse lengths
        for (int len = 1; len <= TS + 1; len++) begin
            bring_up();
            ilim_active = 1'b1;
            repeat (len) tick();
            ilim_active = 1'b0;
            tick();
            tick();
            chk("R6 pulse sweep fault", fault_latched, len == TS + 1);
            chk("R7 pulse sweep pgood", pgood, len < TS + 1);
        end

        // R7: counter restarts from zero between pulses
        bring_up();
        ilim_active = 1'b1;
        repeat (TS) tick();
        ilim_active = 1'b0;
        tick();
        ilim_active = 1'b1;
        repeat (TS) tick();
        ilim_active = 1'b0;
        tick();
        chk("R7 back-to-back no fault", fault_latched, 1'b0);
        chk("R7 back-to-back pgood", pgood, 1'b1);

        // R5: current limit during start-up is ignored until pgood
        enable_in = 1'b0;
        tick();
        ilim_active = 1'b1;
        enable_in = 1'b1;
        for (int k = 1; k <= 2 * NN + 9 + TS; k++) begin
            tick();
            chk("R5 pgood", pgood, (k >= 2 * NN + 8) && (k < 2 * NN + 9 + TS));
            chk("R5 fault", fault_latched, k >= 2 * NN + 9 + TS);
        end
        ilim_active = 1'b0;
        enable_in = 1'b0;
        tick();

        // R3: phase window extends while detection is unfinished
        phase_det_done = 1'b0;
        enable_in = 1'b1;
        repeat (NN + 11) tick();
        chk("R3 held pwm_en", pwm_en, 1'b0);
        chk("R3 held drv_enable", drv_enable, 1'b1);
        phase_det_done = 1'b1;
        tick();
        chk("R3 release pwm_en", pwm_en, 1'b1);

        // R4: soft start waits for both flags
        enable_in = 1'b0;
        tick();
        ss_near_target = 1'b0;
        enable_in = 1'b1;
        repeat (NN + 6) tick();
        chk("R4 soft pwm_en", pwm_en, 1'b1);
        repeat (10) tick();
        chk("R4 wait near-target", pgood, 1'b0);
        ss_near_target = 1'b1;
        blank_done = 1'b0;
        repeat (5) tick();
        chk("R4 wait blanking", pgood, 1'b0);
        blank_done = 1'b1;
        for (int k = 1; k <= NN + 2; k++) begin
            tick();
            chk("R4 delayed pgood", pgood, k >= NN + 2);
        end

        // R1: supply loss mid-sequence and full restart
        enable_in = 1'b0;
        tick();
        enable_in = 1'b1;
        repeat (NN + 8) tick();
        supply_ok = 1'b0;
        tick();
        all_low("R1 supply drop");
        chk("R1 ss_en", ss_en, 1'b0);
        supply_ok = 1'b1;
        for (int k = 1; k <= NN + 6; k++) begin
            tick();
            chk("R1 restart pwm_en", pwm_en, k >= NN + 6);
        end

        // R9: bypass prevents latch; release latches on second edge
        bring_up();
        latch_bypass = 1'b1;
        ilim_active = 1'b1;
        repeat (5 * TS) tick();
        chk("R9 bypass no fault", fault_latched, 1'b0);
        chk("R9 bypass pgood", pgood, 1'b1);
        latch_bypass = 1'b0;
        tick();
        chk("R9 release first edge", fault_latched, 1'b0);
        tick();
        chk("R9 release second edge", fault_latched, 1'b1);
        ilim_active = 1'b0;
        supply_ok = 1'b0;
        tick();
        chk("R8 supply cycle clears", fault_latched, 1'b0);
        supply_ok = 1'b1;
        tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule